// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block runs the register sequence that keeps a CPU clock domain safe while its main PLL is being retuned. A controller raises a pre-change request and passes three values: the current rate, the target rate and the rate of the alternate clock source. The sequencer finds the divider settings for the target rate in an external rate table. When the alternate source would otherwise drive the domain too fast, it first programs a temporary safe divider. It then moves the domain mux onto the alternate source and loads the target divider values. Each step waits until the clock hardware reports that it has settled.

After the PLL has locked at its new rate, a post-change request moves the mux back to the PLL and clears the temporary ratio. If the debug option is built in, the same step also restores the trace-clock field. All accesses go out through a simple valid/ready register master port to the mux/divider control block. Each poll has a cycle-count timeout. A timeout is recorded but does not stop the sequence. Every request ends with a one-cycle done pulse and a three-bit error code.

Top module: `cpuclk_seq`

## Requirements
- R1: Table search steps `tbl_idx` from 0 and picks the first entry where `tbl_prate_khz`×1000 equals the requested new rate. An entry with `tbl_prate_khz` of 0 ends the search. In that case `err[0]` is set and no register write is issued.
- R2: A pre-change uses a safe divider only when the alternate rate is above the old rate, or when the old rate is above the new rate. Otherwise no read-modify-write of the divider word is made, and the first write goes to the mux select register.
- R3: The safe ratio is ceil(alternate / min(old, new)) − 1. If that value would be 8 or more, `err[2]` is set and the ratio is held at 7.
- R4: The safe ratio is applied by reading the divider word (address 0x010), replacing the masked bits and writing it back. The mask is bits [2:0], plus bits [18:16] when the debug option is on. The block then reads the divider status (0x020) until the masked bits are zero, and only after that touches the mux.
- R5: A pre-change sets bit 16 of mux select (0x000) by read-modify-write. It then polls mux status (0x004) until bits [18:16] equal 2. Next it writes the divider word with the table value ORed with the safe word, and polls 0x020 until the whole word is zero.
- R6: When the second divider register is built in, it is written after the first (0x014) and its status (0x024) is polled to zero. The value written is the table value. If bit 20 of mux select is set, the value is instead the register's current bits [6:4] and [2:0], with all other bits zero.
- R7: A post-change clears bit 16 of mux select and polls until status bits [18:16] equal 1. It then rewrites the divider word by read-modify-write. Bits [2:0] become 0. Bits [18:16] are taken from the table entry for the new rate when the debug option is on; the table lookup follows R1.
- R8: A poll that has not succeeded after `TIMEOUT_CYC` cycles sets `err[1]`, and the sequence goes on to its next step.
- R9: Requests are accepted only while `busy` is low, and `pre_req` wins when both are raised. A request raised while busy has no effect. Each accepted request ends with `done` high for exactly one cycle, and `err` is valid during that cycle.
- R10: While `reg_valid` is high and `reg_ready` is low, `reg_valid`, `reg_write`, `reg_addr` and `reg_wdata` stay unchanged.
- R11: With the debug option on, the safe-phase writes (both the read-modify-write and the later full divider write) carry all ones in bits [18:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_req | input | 1 | Start a pre-change sequence |
| post_req | input | 1 | Start a post-change sequence |
| old_rate | input | RW | Current PLL rate in Hz |
| new_rate | input | RW | Target PLL rate in Hz |
| alt_rate | input | RW | Alternate source rate in Hz |
| tbl_idx | output | TW | Rate table index being examined |
| tbl_prate_khz | input | RW | Table entry rate in kHz, 0 ends the table |
| tbl_div0 | input | 32 | Table entry value for the divider word |
| tbl_div1 | input | 32 | Table entry value for the second divider register |
| reg_valid | output | 1 | Register access request |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_addr | output | AW | Register address |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid with reg_ready |
| reg_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | [0] no table entry, [1] poll timeout, [2] safe ratio out of range |

## Verification
The bench targets the safe-divider decision and its arithmetic. It uses a rate drop, an alternate source faster than the old rate, an upward step that needs no safe ratio, and a ratio that overflows; a wrong ceiling or a missing saturation would write a different low field. It checks the order of writes, because a design that changed the mux before the safe ratio had settled, or wrote dividers before the mux status matched, would over-clock the domain. Further scenarios cover the monitor-bit preservation of the second divider, the trace field restored on post-change, a stuck mux status that must time out yet still finish, a missing table entry that must write nothing, and a request raised while busy that must be ignored.

// File: rtl/cpuclk_seq.sv
module cpuclk_seq #(
  parameter int AW = 12,
  parameter int RW = 32,
  parameter int TW = 4,
  parameter int TIMEOUT_CYC = 2000000,
  parameter bit HAS_DIV1 = 1'b1,
  parameter bit DBG_ALT_DIV = 1'b1,
  parameter logic [AW-1:0] A_MUX_SEL   = 'h000,
  parameter logic [AW-1:0] A_MUX_STAT  = 'h004,
  parameter logic [AW-1:0] A_DIV0      = 'h010,
  parameter logic [AW-1:0] A_DIV1      = 'h014,
  parameter logic [AW-1:0] A_DIV0_STAT = 'h020,
  parameter logic [AW-1:0] A_DIV1_STAT = 'h024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_req,
  input  logic          post_req,
  input  logic [RW-1:0] old_rate,
  input  logic [RW-1:0] new_rate,
  input  logic [RW-1:0] alt_rate,
  output logic [TW-1:0] tbl_idx,
  input  logic [RW-1:0] tbl_prate_khz,
  input  logic [31:0]   tbl_div0,
  input  logic [31:0]   tbl_div1,
  output logic          reg_valid,
  output logic          reg_write,
  output logic [AW-1:0] reg_addr,
  output logic [31:0]   reg_wdata,
  input  logic [31:0]   reg_rdata,
  input  logic          reg_ready,
  output logic          busy,
  output logic          done,
  output logic [2:0]    err
);
  localparam int TCW = $clog2(TIMEOUT_CYC + 1);
  localparam int PW  = RW + 10;
  localparam logic [31:0] DBG_MASK = DBG_ALT_DIV ? 32'h0007_0000 : 32'h0;
  localparam logic [31:0] RMW_MASK = 32'h7 | DBG_MASK;
  localparam logic [31:0] SEL_BIT  = 32'h0001_0000;

  typedef enum logic [4:0] {
    IDLE, LOOK, CALC, HPM_RD, D1_RD, RMW_RD, RMW_WR, RMW_POLL,
    MUX_RD, MUX_WR, MUX_POLL, D0_WR, D0_POLL, D1_WR, D1_POLL, FIN
  } st_t;

  st_t            st, pnext;
  logic           post_q, need_q;
  logic [RW-1:0]  old_q, new_q, alt_q;
  logic [31:0]    div0_q, div1_q, safe_q, rd_q;
  logic [3:0]     q_cnt;
  logic [RW+3:0]  acc;
  logic [TCW-1:0] tmo;
  logic [2:0]     err_q;
  logic [TW-1:0]  idx_q;
  logic           is_poll, cond;

  wire [RW-1:0] min_rate = (old_q < new_q) ? old_q : new_q;
  wire [PW-1:0] prod     = PW'(tbl_prate_khz) * PW'(1000);
  wire          match    = prod == PW'(new_q);
  wire          need_w   = (alt_q > old_q) || (old_q > new_q);
  wire          ack      = reg_valid && reg_ready;
  wire          reached  = acc >= (RW+4)'(alt_q);
  wire [2:0]    ratio    = reached ? 3'(q_cnt - 4'd1) : 3'd7;
  wire          tmo_hit  = tmo >= TCW'(TIMEOUT_CYC - 1);

  assign busy    = st != IDLE;
  assign done    = st == FIN;
  assign err     = err_q;
  assign tbl_idx = idx_q;

  always_comb begin
    reg_valid = 1'b1;
    reg_write = 1'b0;
    reg_addr  = A_DIV0;
    reg_wdata = 32'h0;
    is_poll   = 1'b0;
    cond      = 1'b0;
    pnext     = FIN;
    case (st)
      HPM_RD:   reg_addr = A_MUX_SEL;
      D1_RD:    reg_addr = A_DIV1;
      RMW_RD:   reg_addr = A_DIV0;
      RMW_WR: begin
        reg_write = 1'b1;
        reg_wdata = (rd_q & ~RMW_MASK) | (post_q ? (div0_q & DBG_MASK) : safe_q);
      end
      RMW_POLL: begin
        reg_addr = A_DIV0_STAT;
        is_poll  = 1'b1;
        cond     = (reg_rdata & RMW_MASK) == 32'h0;
        pnext    = post_q ? FIN : MUX_RD;
      end
      MUX_RD:   reg_addr = A_MUX_SEL;
      MUX_WR: begin
        reg_write = 1'b1;
        reg_addr  = A_MUX_SEL;
        reg_wdata = post_q ? (rd_q & ~SEL_BIT) : (rd_q | SEL_BIT);
      end
      MUX_POLL: begin
        reg_addr = A_MUX_STAT;
        is_poll  = 1'b1;
        cond     = reg_rdata[18:16] == (post_q ? 3'd1 : 3'd2);
        pnext    = post_q ? RMW_RD : D0_WR;
      end
      D0_WR: begin
        reg_write = 1'b1;
        reg_wdata = div0_q | safe_q;
      end
      D0_POLL: begin
        reg_addr = A_DIV0_STAT;
        is_poll  = 1'b1;
        cond     = reg_rdata == 32'h0;
        pnext    = HAS_DIV1 ? D1_WR : FIN;
      end
      D1_WR: begin
        reg_write = 1'b1;
        reg_addr  = A_DIV1;
        reg_wdata = div1_q;
      end
      D1_POLL: begin
        reg_addr = A_DIV1_STAT;
        is_poll  = 1'b1;
        cond     = reg_rdata == 32'h0;
      end
      default:  reg_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; post_q <= 1'b0; need_q <= 1'b0;
      old_q <= '0; new_q <= '0; alt_q <= '0;
      div0_q <= '0; div1_q <= '0; safe_q <= '0; rd_q <= '0;
      q_cnt <= '0; acc <= '0; tmo <= '0; err_q <= '0; idx_q <= '0;
    end else begin
      if (is_poll) begin
        if (ack && (cond || tmo_hit)) begin
          if (!cond) err_q[1] <= 1'b1;
          st  <= pnext;
          tmo <= '0;
        end else if (!tmo_hit) begin
          tmo <= tmo + 1'b1;
        end
      end
      case (st)
        IDLE: if (pre_req || post_req) begin
          post_q <= !pre_req;
          old_q <= old_rate; new_q <= new_rate; alt_q <= alt_rate;
          idx_q <= '0; err_q <= '0; safe_q <= '0; tmo <= '0;
          st <= (pre_req || DBG_ALT_DIV) ? LOOK : MUX_RD;
        end
        LOOK: begin
          if (tbl_prate_khz == '0) begin
            err_q[0] <= 1'b1;
            st <= FIN;
          end else if (match) begin
            div0_q <= tbl_div0;
            div1_q <= tbl_div1;
            need_q <= need_w;
            acc    <= (RW+4)'(min_rate);
            q_cnt  <= 4'd1;
            if (post_q)      st <= MUX_RD;
            else if (need_w) st <= CALC;
            else             st <= HAS_DIV1 ? HPM_RD : MUX_RD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        CALC: begin
          if (reached || q_cnt == 4'd8) begin
            safe_q <= {29'h0, ratio} | DBG_MASK;
            if (!reached) err_q[2] <= 1'b1;
            st <= HAS_DIV1 ? HPM_RD : RMW_RD;
          end else begin
            acc   <= acc + (RW+4)'(min_rate);
            q_cnt <= q_cnt + 4'd1;
          end
        end
        HPM_RD: if (ack) st <= reg_rdata[20] ? D1_RD : (need_q ? RMW_RD : MUX_RD);
        D1_RD: if (ack) begin
          div1_q <= reg_rdata & 32'h0000_0077;
          st <= need_q ? RMW_RD : MUX_RD;
        end
        RMW_RD: if (ack) begin rd_q <= reg_rdata; st <= RMW_WR; end
        RMW_WR: if (ack) st <= RMW_POLL;
        MUX_RD: if (ack) begin rd_q <= reg_rdata; st <= MUX_WR; end
        MUX_WR: if (ack) st <= MUX_POLL;
        D0_WR:  if (ack) st <= D0_POLL;
        D1_WR:  if (ack) st <= D1_POLL;
        FIN:    st <= IDLE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpuclk_seq_chk.sv
module cpuclk_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pre_req,
  input logic          post_req,
  input logic          busy,
  input logic          done,
  input logic [2:0]    err,
  input logic          reg_valid,
  input logic          reg_ready,
  input logic          reg_write,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata
);
  logic [7:0] wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     wr_cnt <= '0;
    else if (!busy)                                 wr_cnt <= '0;
    else if (reg_valid && reg_ready && reg_write && wr_cnt != 8'hff) wr_cnt <= wr_cnt + 8'd1;
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pre_req && !post_req) |=> !busy);

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_write) &&
                                  $stable(reg_addr) && $stable(reg_wdata)));

  // R1
  no_entry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err[0]) |-> (wr_cnt == 8'd0));
endmodule

bind cpuclk_seq cpuclk_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .post_req(post_req),
  .busy(busy), .done(done), .err(err), .reg_valid(reg_valid),
  .reg_ready(reg_ready), .reg_write(reg_write), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/cpuclk_seq_tb.sv
`timescale 1ns/1ps
module cpuclk_seq_tb;
  localparam logic [11:0] A_MS = 12'h000, A_MST = 12'h004, A_D0 = 12'h010,
                          A_D1 = 12'h014, A_D0S = 12'h020, A_D1S = 12'h024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pre_req = 1'b0, post_req = 1'b0;
  logic [31:0] old_rate = '0, new_rate = '0, alt_rate = '0;
  logic [3:0]  tbl_idx;
  logic [31:0] tbl_prate_khz, tbl_div0, tbl_div1;
  logic reg_valid, reg_write, reg_ready, busy, done;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0]  err;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cpuclk_seq #(.TIMEOUT_CYC(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .post_req(post_req),
    .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
    .tbl_idx(tbl_idx), .tbl_prate_khz(tbl_prate_khz), .tbl_div0(tbl_div0),
    .tbl_div1(tbl_div1), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .busy(busy), .done(done), .err(err)
  );

  always_comb begin
    case (tbl_idx)
      4'd0: begin tbl_prate_khz = 32'd1000000; tbl_div0 = 32'h0013_0200; tbl_div1 = 32'h53; end
      4'd1: begin tbl_prate_khz = 32'd800000;  tbl_div0 = 32'h0012_0100; tbl_div1 = 32'h42; end
      4'd2: begin tbl_prate_khz = 32'd500000;  tbl_div0 = 32'h0011_0000; tbl_div1 = 32'h31; end
      default: begin tbl_prate_khz = 32'd0; tbl_div0 = 32'h0; tbl_div1 = 32'h0; end
    endcase
  end

  // register block model
  logic [31:0] mux_r, d0_r, d1_r, pm, pd0, pd1;
  logic [2:0]  mcnt, c0, c1;
  logic        load = 1'b0, stuck = 1'b0, stall_en = 1'b0;
  logic [7:0]  cyc;
  logic [11:0] wl_a [256];
  logic [31:0] wl_d [256];
  int          wcount = 0, dcount = 0;

  assign reg_ready = !(stall_en && cyc[0]);

  always_comb begin
    case (reg_addr)
      A_MS:  reg_rdata = mux_r;
      A_MST: reg_rdata = (stuck || mcnt != 0) ? 32'h0004_0000 : (mux_r[16] ? 32'h0002_0000 : 32'h0001_0000);
      A_D0:  reg_rdata = d0_r;
      A_D1:  reg_rdata = d1_r;
      A_D0S: reg_rdata = (c0 != 0) ? 32'h0001_0001 : 32'h0;
      A_D1S: reg_rdata = (c1 != 0) ? 32'h0000_0100 : 32'h0;
      default: reg_rdata = 32'hdead_beef;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (done) dcount <= dcount + 1;
    if (mcnt != 0) mcnt <= mcnt - 3'd1;
    if (c0 != 0) c0 <= c0 - 3'd1;
    if (c1 != 0) c1 <= c1 - 3'd1;
    if (load) begin mux_r <= pm; d0_r <= pd0; d1_r <= pd1; end
    if (reg_valid && reg_ready && reg_write) begin
      wl_a[wcount[7:0]] <= reg_addr;
      wl_d[wcount[7:0]] <= reg_wdata;
      wcount <= wcount + 1;
      case (reg_addr)
        A_MS: begin mux_r <= reg_wdata; mcnt <= 3'd3; end
        A_D0: begin d0_r <= reg_wdata; c0 <= 3'd3; end
        A_D1: begin d1_r <= reg_wdata; c1 <= 3'd3; end
        default: ;
      endcase
    end
  end

  initial begin
    cyc = '0; mcnt = '0; c0 = '0; c1 = '0;
    mux_r = '0; d0_r = '0; d1_r = '0; pm = '0; pd0 = '0; pd1 = '0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkw(input string req, input int base, input int i,
                      input logic [11:0] a, input logic [31:0] d);
    chk({req, " addr"}, {20'h0, wl_a[base + i]}, {20'h0, a});
    chk({req, " data"}, wl_d[base + i], d);
  endtask

  task automatic preset(input logic [31:0] m, input logic [31:0] a0, input logic [31:0] a1);
    @(negedge clk); pm = m; pd0 = a0; pd1 = a1; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic start(input bit post, input logic [31:0] o, input logic [31:0] n, input logic [31:0] a);
    @(negedge clk);
    old_rate = o; new_rate = n; alt_rate = a;
    if (post) post_req = 1'b1; else pre_req = 1'b1;
    @(negedge clk);
    pre_req = 1'b0; post_req = 1'b0;
  endtask

  task automatic finish_seq(output logic [2:0] e);
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    e = err;
    @(negedge clk);
  endtask

  task automatic run(input bit post, input logic [31:0] o, input logic [31:0] n,
                     input logic [31:0] a, output int base, output logic [2:0] e);
    base = wcount;
    start(post, o, n, a);
    finish_seq(e);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", {31'h0, busy}, 32'h0);
    chk("R9 reset done", {31'h0, done}, 32'h0);
    chk("R9 reset valid", {31'h0, reg_valid}, 32'h0);
  endtask

  task automatic t_up_nosafe();
    int b; logic [2:0] e;
    preset(32'h0, 32'h0005_4321, 32'h0);
    run(1'b0, 32'd500_000_000, 32'd1_000_000_000, 32'd400_000_000, b, e);
    chk("R2 writes", wcount - b, 3);
    chkw("R2 mux first", b, 0, A_MS, 32'h0001_0000);
    chkw("R5 div0", b, 1, A_D0, 32'h0013_0200);
    chkw("R6 div1", b, 2, A_D1, 32'h53);
    chk("R9 err", {29'h0, e}, 0);
  endtask

  task automatic t_down();
    int b; logic [2:0] e;
    preset(32'h0, 32'h0005_4321, 32'h0);
    run(1'b0, 32'd1_000_000_000, 32'd500_000_000, 32'd800_000_000, b, e);
    chk("R4 writes", wcount - b, 4);
    chkw("R4 R11 safe rmw", b, 0, A_D0, 32'h0007_4321);
    chkw("R4 mux after safe", b, 1, A_MS, 32'h0001_0000);
    chkw("R5 R11 div0 or safe", b, 2, A_D0, 32'h0017_0001);
    chkw("R6 div1", b, 3, A_D1, 32'h31);
    chk("R3 err", {29'h0, e}, 0);
  endtask

  task automatic t_alt_fast();
    int b; logic [2:0] e;
    preset(32'h0, 32'h0005_4321, 32'h0);
    stall_en = 1'b1;
    run(1'b0, 32'd500_000_000, 32'd800_000_000, 32'd1_200_000_000, b, e);
    stall_en = 1'b0;
    chk("R2 writes", wcount - b, 4);
    chkw("R3 ratio 2", b, 0, A_D0, 32'h0007_4322);
    chkw("R10 mux", b, 1, A_MS, 32'h0001_0000);
    chkw("R3 div0", b, 2, A_D0, 32'h0017_0102);
    chkw("R6 div1", b, 3, A_D1, 32'h42);
  endtask

  task automatic t_overflow();
    int b; logic [2:0] e;
    preset(32'h0, 32'h0005_4321, 32'h0);
    run(1'b0, 32'd100_000_000, 32'd500_000_000, 32'd1_000_000_000, b, e);
    chk("R3 warn", {29'h0, e}, 32'h4);
    chkw("R3 saturated", b, 0, A_D0, 32'h0007_4327);
    chkw("R3 div0", b, 2, A_D0, 32'h0017_0007);
  endtask

  task automatic t_noentry();
    int b; logic [2:0] e;
    run(1'b0, 32'd500_000_000, 32'd123_456, 32'd400_000_000, b, e);
    chk("R1 err pre", {29'h0, e}, 32'h1);
    chk("R1 no writes pre", wcount - b, 0);
    run(1'b1, 32'd500_000_000, 32'd777, 32'd400_000_000, b, e);
    chk("R7 R1 err post", {29'h0, e}, 32'h1);
    chk("R7 R1 no writes post", wcount - b, 0);
  endtask

  task automatic t_monitor();
    int b; logic [2:0] e;
    preset(32'h0010_0000, 32'h0005_4321, 32'h1234_5677);
    run(1'b0, 32'd500_000_000, 32'd1_000_000_000, 32'd400_000_000, b, e);
    chkw("R5 mux keeps bit20", b, 0, A_MS, 32'h0011_0000);
    chkw("R6 div1 preserved", b, 2, A_D1, 32'h77);
  endtask

  task automatic t_post();
    int b; logic [2:0] e;
    preset(32'h0001_0000, 32'h0017_0102, 32'h0);
    run(1'b1, 32'd500_000_000, 32'd800_000_000, 32'd1_200_000_000, b, e);
    chk("R7 writes", wcount - b, 2);
    chkw("R7 mux back", b, 0, A_MS, 32'h0);
    chkw("R7 R11 restore", b, 1, A_D0, 32'h0012_0100);
    chk("R7 err", {29'h0, e}, 0);
  endtask

  task automatic t_timeout();
    int b; logic [2:0] e;
    preset(32'h0, 32'h0, 32'h0);
    stuck = 1'b1;
    run(1'b0, 32'd500_000_000, 32'd1_000_000_000, 32'd400_000_000, b, e);
    stuck = 1'b0;
    chk("R8 err", {29'h0, e}, 32'h2);
    chk("R8 continued", wcount - b, 3);
    chkw("R8 div0 after timeout", b, 1, A_D0, 32'h0013_0200);
  endtask

  task automatic t_busy_ignore();
    int b, d0; logic [2:0] e;
    preset(32'h0, 32'h0, 32'h0);
    b = wcount; d0 = dcount;
    start(1'b0, 32'd500_000_000, 32'd1_000_000_000, 32'd400_000_000);
    repeat (3) @(negedge clk);
    new_rate = 32'd42; post_req = 1'b1; pre_req = 1'b1;
    @(negedge clk);
    post_req = 1'b0; pre_req = 1'b0;
    finish_seq(e);
    repeat (4) @(negedge clk);
    chk("R9 ignored err", {29'h0, e}, 0);
    chk("R9 ignored writes", wcount - b, 3);
    chk("R9 one done", dcount - d0, 1);
    chk("R9 idle after", {31'h0, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_up_nosafe();
    t_down();
    t_alt_fast();
    t_overflow();
    t_noentry();
    t_monitor();
    t_post();
    t_timeout();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule